// File: doc/BRIEF.md
# Load-Balanced Cell Switch with Frame Sequencing

This block is an N-port cell switch with two stages, and it keeps cells in order. Neither stage arbitrates. A free-running slot counter sets both connection patterns as fixed cyclic shifts. Every external input keeps one coordination buffer per destination. Through the first shift it passes cells of each (input, output) flow to the intermediate ports. Each cell of a flow goes to the intermediate port that follows the port used by the previous cell of that flow, so a frame of N cells covers every intermediate port once.

Each intermediate port holds a separate queue for every (input, output) pair. Cells from one input therefore never wait behind cells from another input. Through the second shift, each output reads a flow from the intermediate ports in the same rotating order that was used to write it. When the next expected queue is empty, the output waits for it and does not skip ahead.

Cells arrive on per-port valid/ready interfaces with a destination index and a sequence tag. They leave on per-port registered outputs that carry the source index and the unchanged tag.

Top module: `lbs_switch`

## Requirements
- R1: After reset all `out_valid` bits are 0 and all `in_ready` bits are 1.
- R2: Every cell accepted on input i with destination d leaves exactly once on output d. No cell appears that was not accepted.
- R3: Cells of the same (input, output) flow leave in the order they were accepted, with the tag unchanged.
- R4: `out_src` of an emitted cell equals the index of the input port that accepted it.
- R5: The slot counter is 0 after reset and advances by 1 modulo N each clock. In slot t, input i can write only to intermediate port (i+t) mod N, and output o can read only from intermediate port (o−t) mod N. After reset each flow's first cell uses intermediate port 0, and later cells use the ports that follow in turn. The cell read in cycle e shows on the output in cycle e+1.
- R6: `in_ready[i]` is low while the coordination buffer at input i for `in_dst[i]` is full, and a cell offered while it is low is not taken. Sustained overload of one output drives ready low.
- R7: With `FLUSH_PARTIAL` set, a lone cell in an otherwise idle switch is emitted no later than 2N+1 cycles after the cycle in which it was accepted. Incomplete frames are sent when no complete frame or frame in progress is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Cell offered, one bit per input |
| in_ready | output | N | Cell can be taken, one bit per input |
| in_dst | input | N*IW | Destination output index per input |
| in_seq | input | N*SEQ_W | Sequence tag per input |
| out_valid | output | N | Cell emitted, one bit per output |
| out_src | output | N*IW | Source input index per output |
| out_seq | output | N*SEQ_W | Sequence tag per output |

## Verification
A cell is accepted at the edge that ends its offer cycle. It can leave the coordination buffer in the first later cycle whose slot connects its input to the flow's next intermediate port. It can be read in the first cycle after that whose slot connects that port to its output, and it appears one cycle after the read. The bench derives this exact cycle from the slot count for lone cells sent just after reset. It also checks the 2N+1 bound for those cells. Outputs are sampled on the falling edge. Under loaded traffic the arrival time depends on queue state, so the scoreboard checks order, tag, source and completeness rather than timing.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;

   // Eligibility class of a flow at an ingress; larger value wins.
   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_PART = 2'd1,
      CLS_FULL = 2'd2,
      CLS_CONT = 2'd3
   } cls_e;

   function automatic int unsigned wrap_add(input int unsigned a, input int unsigned b,
                                            input int unsigned n);
      return (a + b) % n;
   endfunction

   function automatic int unsigned wrap_sub(input int unsigned a, input int unsigned b,
                                            input int unsigned n);
      return (a + n - (b % n)) % n;
   endfunction

endpackage

// File: rtl/lbs_fifo.sv
`timescale 1ns/1ps
module lbs_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          full,
   output logic [CW-1:0] count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign dout = mem[rp];
   assign full = (count == CW'(DEPTH));
endmodule

// File: rtl/lbs_ingress.sv
`timescale 1ns/1ps
module lbs_ingress
   import lbs_pkg::*;
#(
   parameter int N             = 4,
   parameter int SEQ_W         = 8,
   parameter int VOQ_DEPTH     = 8,
   parameter bit FLUSH_PARTIAL = 1'b1,
   localparam int IW           = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    link,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [IW-1:0]    in_dst,
   input  logic [SEQ_W-1:0] in_seq,
   input  logic [N-1:0]     mid_full,
   output logic             tx_valid,
   output logic [IW-1:0]    tx_dst,
   output logic [SEQ_W-1:0] tx_seq
);
   localparam int CW = $clog2(VOQ_DEPTH + 1);
   localparam int LW = $clog2(N + 1);

   logic [N-1:0]     voq_push, voq_pop, voq_full, part_en;
   logic [CW-1:0]    voq_cnt  [N];
   logic [SEQ_W-1:0] voq_head [N];
   logic [IW-1:0]    wr_ptr   [N];
   logic [LW-1:0]    left     [N];
   cls_e             cls      [N];
   cls_e             best_cls;
   logic [IW-1:0]    sel, next_link;

   for (genvar d = 0; d < N; d++) begin : g_voq
      assign voq_push[d] = in_valid && in_ready && (in_dst == IW'(d));
      assign voq_pop[d]  = tx_valid && (sel == IW'(d));
      lbs_fifo #(.W(SEQ_W), .DEPTH(VOQ_DEPTH)) i_voq (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (voq_push[d]),
         .din   (in_seq),
         .pop   (voq_pop[d]),
         .dout  (voq_head[d]),
         .full  (voq_full[d]),
         .count (voq_cnt[d])
      );
   end

   // Variant: incomplete frames either drain or wait for N cells.
   if (FLUSH_PARTIAL) begin : g_flush
      for (genvar d = 0; d < N; d++) begin : g_pe
         assign part_en[d] = (voq_cnt[d] != '0);
      end
   end else begin : g_hold
      assign part_en = '0;
   end

   assign in_ready = !voq_full[in_dst];

   always_comb begin
      for (int d = 0; d < N; d++) begin
         cls[d] = CLS_NONE;
         if (wr_ptr[d] == link && !mid_full[d]) begin
            if (left[d] != '0)                cls[d] = CLS_CONT;
            else if (voq_cnt[d] >= CW'(N))    cls[d] = CLS_FULL;
            else if (part_en[d])              cls[d] = CLS_PART;
         end
      end
   end

   always_comb begin
      best_cls = CLS_NONE;
      sel      = '0;
      for (int d = 0; d < N; d++) begin
         if (cls[d] > best_cls) begin
            best_cls = cls[d];
            sel      = IW'(d);
         end
      end
   end

   assign tx_valid  = (best_cls != CLS_NONE);
   assign tx_dst    = sel;
   assign tx_seq    = voq_head[sel];
   assign next_link = IW'(wrap_add(32'(link), 1, N));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < N; d++) begin
            wr_ptr[d] <= '0;
            left[d]   <= '0;
         end
      end else if (tx_valid) begin
         wr_ptr[sel] <= next_link;
         if (best_cls == CLS_CONT)      left[sel] <= left[sel] - LW'(1);
         else if (best_cls == CLS_FULL) left[sel] <= LW'(N - 1);
         else                           left[sel] <= LW'(voq_cnt[sel] - CW'(1));
      end
   end
endmodule

// File: rtl/lbs_egress.sv
`timescale 1ns/1ps
module lbs_egress #(
   parameter int N     = 4,
   parameter int SEQ_W = 8,
   localparam int IW   = $clog2(N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IW-1:0]      link,
   input  logic [N-1:0]       head_valid,
   input  logic [N*SEQ_W-1:0] head_seq,
   output logic [N-1:0]       pop,
   output logic               out_valid,
   output logic [IW-1:0]      out_src,
   output logic [SEQ_W-1:0]   out_seq
);
   logic [IW-1:0] rd_ptr [N];
   logic [IW-1:0] sel;
   logic          hit;

   always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (head_valid[i] && rd_ptr[i] == link) begin
            hit = 1'b1;
            sel = IW'(i);
         end
      end
   end

   assign pop = hit ? ({{(N-1){1'b0}}, 1'b1} << sel) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) rd_ptr[i] <= '0;
         out_valid <= 1'b0;
         out_src   <= '0;
         out_seq   <= '0;
      end else begin
         out_valid <= hit;
         if (hit) begin
            rd_ptr[sel] <= (link == IW'(N - 1)) ? '0 : link + IW'(1);
            out_src     <= sel;
            out_seq     <= head_seq[sel*SEQ_W +: SEQ_W];
         end
      end
   end
endmodule

// File: rtl/lbs_switch.sv
`timescale 1ns/1ps
module lbs_switch
   import lbs_pkg::*;
#(
   parameter int N             = 4,
   parameter int SEQ_W         = 8,
   parameter int VOQ_DEPTH     = 8,
   parameter int MID_DEPTH     = 4,
   parameter bit FLUSH_PARTIAL = 1'b1,
   localparam int IW           = $clog2(N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       in_valid,
   output logic [N-1:0]       in_ready,
   input  logic [N*IW-1:0]    in_dst,
   input  logic [N*SEQ_W-1:0] in_seq,
   output logic [N-1:0]       out_valid,
   output logic [N*IW-1:0]    out_src,
   output logic [N*SEQ_W-1:0] out_seq
);
   localparam int NQ  = N * N * N;
   localparam int QCW = $clog2(MID_DEPTH + 1);

   if (N < 2) begin : g_bad_n
      $error("lbs_switch: N must be at least 2");
   end
   if (VOQ_DEPTH < N) begin : g_bad_voq
      $error("lbs_switch: VOQ_DEPTH must hold a full frame of N cells");
   end
   if (MID_DEPTH < 1) begin : g_bad_mid
      $error("lbs_switch: MID_DEPTH must be at least 1");
   end

   function automatic int qidx(input int j, input int i, input int d);
      return (j * N + i) * N + d;
   endfunction

   logic [IW-1:0]      slot;
   logic [IW-1:0]      in_link  [N];
   logic [IW-1:0]      out_link [N];
   logic [N-1:0]       ing_txv;
   logic [IW-1:0]      ing_txd  [N];
   logic [SEQ_W-1:0]   ing_txs  [N];
   logic [N-1:0]       ing_mfull [N];
   logic [NQ-1:0]      q_push, q_pop, q_full, q_avail;
   logic [QCW-1:0]     q_cnt  [NQ];
   logic [SEQ_W-1:0]   q_dout [NQ];
   logic [N-1:0]       eg_hv  [N];
   logic [N*SEQ_W-1:0] eg_hs  [N];
   logic [N-1:0]       eg_pop [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    slot <= '0;
      else if (slot == IW'(N - 1))   slot <= '0;
      else                           slot <= slot + IW'(1);
   end

   always_comb begin
      for (int p = 0; p < N; p++) begin
         in_link[p]  = IW'(wrap_add(p, 32'(slot), N));
         out_link[p] = IW'(wrap_sub(p, 32'(slot), N));
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_ing
      lbs_ingress #(.N(N), .SEQ_W(SEQ_W), .VOQ_DEPTH(VOQ_DEPTH),
                    .FLUSH_PARTIAL(FLUSH_PARTIAL)) i_ing (
         .clk      (clk),
         .rst_n    (rst_n),
         .link     (in_link[i]),
         .in_valid (in_valid[i]),
         .in_ready (in_ready[i]),
         .in_dst   (in_dst[i*IW +: IW]),
         .in_seq   (in_seq[i*SEQ_W +: SEQ_W]),
         .mid_full (ing_mfull[i]),
         .tx_valid (ing_txv[i]),
         .tx_dst   (ing_txd[i]),
         .tx_seq   (ing_txs[i])
      );
   end

   for (genvar q = 0; q < NQ; q++) begin : g_mid
      lbs_fifo #(.W(SEQ_W), .DEPTH(MID_DEPTH)) i_q (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (q_push[q]),
         .din   (ing_txs[(q / N) % N]),
         .pop   (q_pop[q]),
         .dout  (q_dout[q]),
         .full  (q_full[q]),
         .count (q_cnt[q])
      );
      assign q_avail[q] = (q_cnt[q] != '0);
   end

   always_comb begin
      for (int i = 0; i < N; i++)
         for (int d = 0; d < N; d++)
            ing_mfull[i][d] = q_full[qidx(int'(in_link[i]), i, d)];
   end

   always_comb begin
      q_push = '0;
      for (int i = 0; i < N; i++)
         if (ing_txv[i]) q_push[qidx(int'(in_link[i]), i, int'(ing_txd[i]))] = 1'b1;
   end

   always_comb begin
      for (int o = 0; o < N; o++)
         for (int i = 0; i < N; i++) begin
            eg_hv[o][i]                 = q_avail[qidx(int'(out_link[o]), i, o)];
            eg_hs[o][i*SEQ_W +: SEQ_W] = q_dout[qidx(int'(out_link[o]), i, o)];
         end
   end

   always_comb begin
      q_pop = '0;
      for (int o = 0; o < N; o++)
         for (int i = 0; i < N; i++)
            if (eg_pop[o][i]) q_pop[qidx(int'(out_link[o]), i, o)] = 1'b1;
   end

   for (genvar o = 0; o < N; o++) begin : g_eg
      lbs_egress #(.N(N), .SEQ_W(SEQ_W)) i_eg (
         .clk        (clk),
         .rst_n      (rst_n),
         .link       (out_link[o]),
         .head_valid (eg_hv[o]),
         .head_seq   (eg_hs[o]),
         .pop        (eg_pop[o]),
         .out_valid  (out_valid[o]),
         .out_src    (out_src[o*IW +: IW]),
         .out_seq    (out_seq[o*SEQ_W +: SEQ_W])
      );
   end
endmodule

// File: rtl/lbs_switch_chk.sv
`timescale 1ns/1ps
module lbs_switch_chk #(
   parameter int N = 4,
   localparam int NQ = N * N * N
) (
   input logic          clk,
   input logic          rst_n,
   input logic [NQ-1:0] q_push,
   input logic [NQ-1:0] q_pop,
   input logic [NQ-1:0] q_full,
   input logic [NQ-1:0] q_avail
);
   localparam int PER_MID = N * N;

   AST_MID_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push & q_full) == '0);  // R2

   AST_MID_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pop & ~q_avail) == '0);  // R2

   for (genvar q = 0; q < NQ; q++) begin : g_q
      AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         (q_push[q] && !q_pop[q]) |=> q_avail[q]);  // R2
   end

   for (genvar j = 0; j < N; j++) begin : g_j
      AST_ONE_WRITE_PER_MID: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(q_push[j*PER_MID +: PER_MID]) <= 1);  // R5
      AST_ONE_READ_PER_MID: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(q_pop[j*PER_MID +: PER_MID]) <= 1);  // R5
   end
endmodule

bind lbs_switch lbs_switch_chk #(.N(N)) i_lbs_switch_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .q_push  (q_push),
   .q_pop   (q_pop),
   .q_full  (q_full),
   .q_avail (q_avail)
);

// File: tb/test_lbs_switch.sv
`timescale 1ns/1ps
module test_lbs_switch;
   localparam int N     = 4;
   localparam int SEQ_W = 8;
   localparam int IW    = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [N-1:0]       in_valid = '0;
   logic [N-1:0]       in_ready;
   logic [N*IW-1:0]    in_dst = '0;
   logic [N*SEQ_W-1:0] in_seq = '0;
   logic [N-1:0]       out_valid;
   logic [N*IW-1:0]    out_src;
   logic [N*SEQ_W-1:0] out_seq;

   lbs_switch #(.N(N), .SEQ_W(SEQ_W)) i_lbs_switch (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_dst(in_dst), .in_seq(in_seq), .out_valid(out_valid),
      .out_src(out_src), .out_seq(out_seq));

   always #2.5 clk = ~clk;

   int checks = 0, failures = 0, accepted = 0, delivered = 0, blocked = 0;
   int cyc = 0;
   bit done = 0, mon_en = 0;
   int unsigned expq [N][N][$];
   int seqc [N][N];
   logic [N-1:0] dv = '0;
   int dd [N];
   int last_cyc [N];
   int last_src [N];

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic fail(input string msg, input int act, input int exp);
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
   endtask

   function automatic int pending();
      int s = 0;
      for (int i = 0; i < N; i++)
         for (int d = 0; d < N; d++) s += expq[i][d].size();
      return s;
   endfunction

   // Exact output cycle of a lone first cell of a flow after reset (R5).
   function automatic int predict(input int i, input int d, input int c_push);
      int c = c_push + 1;
      int e;
      while ((i + c) % N != 0) c++;
      e = c + 1;
      while (e % N != d) e++;
      return e + 1;
   endfunction

   // Driver: called at a falling edge, drives one cycle, records accepted cells.
   task automatic step();
      for (int i = 0; i < N; i++) begin
         in_valid[i]                = dv[i];
         in_dst[i*IW +: IW]         = IW'(dd[i]);
         in_seq[i*SEQ_W +: SEQ_W]   = SEQ_W'(seqc[i][dd[i]]);
      end
      #1;
      for (int i = 0; i < N; i++) begin
         if (dv[i] && in_ready[i]) begin
            expq[i][dd[i]].push_back(seqc[i][dd[i]] & 255);
            seqc[i][dd[i]]++;
            accepted++;
         end else if (dv[i]) begin
            blocked++;
         end
      end
      @(negedge clk);
   endtask

   // Monitor: pops expected cells and compares.
   always @(negedge clk) begin : mon
      int src, sq;
      int unsigned e;
      if (rst_n && mon_en) begin
         for (int o = 0; o < N; o++) begin
            if (out_valid[o]) begin
               src = int'(out_src[o*IW +: IW]);
               sq  = int'(out_seq[o*SEQ_W +: SEQ_W]);
               last_cyc[o] = cyc;
               last_src[o] = src;
               delivered++;
               checks++;
               if (expq[src][o].size() == 0) begin
                  fail("R2 R6 unexpected cell on output", o, -1);
               end else begin
                  e = expq[src][o].pop_front();
                  if (int'(e) != sq) fail("R3 R4 flow order/tag", sq, int'(e));
               end
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fail("watchdog expired", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int p1, p2;
      for (int i = 0; i < N; i++) begin
         dd[i] = 0;
         last_cyc[i] = -1;
         last_src[i] = -1;
         for (int d = 0; d < N; d++) seqc[i][d] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;   // released at a falling edge: cycle 0
      mon_en = 1'b1;
      #1;
      checks++;
      if (out_valid !== '0) fail("R1 out_valid after reset", int'(out_valid), 0);
      checks++;
      if (in_ready !== '1) fail("R1 in_ready after reset", int'(in_ready), 15);

      // Lone cells: input 1 -> output 2, input 2 -> output 3, accepted in cycle 2.
      @(negedge clk);
      @(negedge clk);
      dv = 4'b0110; dd[1] = 2; dd[2] = 3;
      step();
      dv = '0;
      p1 = predict(1, 2, 2);
      p2 = predict(2, 3, 2);
      repeat (14) step();
      checks++;
      if (last_cyc[2] != p1) fail("R5 lone cell cycle out2", last_cyc[2], p1);
      checks++;
      if (last_cyc[3] != p2) fail("R5 lone cell cycle out3", last_cyc[3], p2);
      checks++;
      if (last_src[2] != 1) fail("R4 source index out2", last_src[2], 1);
      checks++;
      if (last_src[3] != 2) fail("R4 source index out3", last_src[3], 2);
      checks++;
      if (last_cyc[2] - 2 > 2*N + 1) fail("R7 lone cell latency", last_cyc[2] - 2, 2*N + 1);
      checks++;
      if (last_cyc[3] - 2 > 2*N + 1) fail("R7 lone cell latency", last_cyc[3] - 2, 2*N + 1);

      // Frames: two full frames plus a partial one from input 0, mixed with input 3.
      for (int k = 0; k < 9; k++) begin
         dv = 4'b1001; dd[0] = 3; dd[3] = (k % 2 == 0) ? 3 : 1;
         step();
      end
      dv = '0;
      repeat (40) step();
      checks++;
      if (pending() != 0) fail("R3 frame traffic not drained", pending(), 0);

      // Mixed random traffic.
      for (int k = 0; k < 400; k++) begin
         for (int i = 0; i < N; i++) begin
            dv[i] = ($urandom_range(0, 1) == 1);
            dd[i] = int'($urandom_range(0, N - 1));
         end
         step();
      end

      // Overload of output 0 from all inputs.
      blocked = 0;
      for (int k = 0; k < 150; k++) begin
         dv = '1;
         for (int i = 0; i < N; i++) dd[i] = 0;
         step();
      end
      checks++;
      if (blocked == 0) fail("R6 ready never deasserted under overload", blocked, 1);

      dv = '0;
      for (int k = 0; k < 3000 && pending() != 0; k++) step();
      repeat (2*N + 4) step();
      checks++;
      if (pending() != 0) fail("R2 cells lost", pending(), 0);
      checks++;
      if (delivered != accepted) fail("R2 delivered vs accepted", delivered, accepted);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule